// File: doc/BRIEF.md
# Dual-Read Parity-Decoded Banked Memory

This block is a word-addressed memory that accepts two independent reads in the same clock cycle while every storage bank underneath it has only one port. Words are spread across four main banks by the low address bits. A fifth bank holds, for each row, the bitwise XOR of that row in all four main banks.

Reads to different banks, or to the very same address, are served directly. When both reads land in one bank at different rows, port A gets that bank directly. Port B's word is rebuilt from the parity row XORed with the same row of the three other main banks, so the busy bank is touched only once. The conflict costs no stall.

A single write port keeps the parity bank consistent with a two-cycle sequence. In the first cycle the untouched banks are read at the target row. In the second the new word is stored and the refreshed parity is written. Reads are held off through `rd_ready` while a write is in flight.

Top module: `xpm_dualread`

## Requirements
- R1: A read pair accepted in cycle t (`rd_en` and `rd_ready` both high at the edge) raises `rd_valid` for exactly the following cycle, with both data outputs valid in that cycle. A cycle with no accepted pair leaves `rd_valid` low in the next cycle.
- R2: Address bits [1:0] pick the main bank and bits [7:2] pick the row. Every one of the 256 addresses holds its own word, and a read returns the last value written there.
- R3: When the two read addresses are in different banks, both ports return their stored words.
- R4: When the two read addresses are in the same bank at different rows, port A returns its word from the bank and port B returns its word rebuilt from parity. This stays correct after any sequence of writes.
- R5: When the two read addresses are identical, both ports return the same stored word.
- R6: A write accepted in cycle t (`wr_en` and `wr_ready` high) drops `wr_ready` in cycle t+1 and raises it again in cycle t+2. A read accepted in cycle t+2 or later returns the new word.
- R7: `rd_ready` is low in any cycle where `wr_en` is high or a write is completing. A read requested in such a cycle is ignored: `rd_valid` stays low in the next cycle.
- R8: After reset every address reads as zero on both ports, including conflicting pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; clears all banks |
| rd_en | input | 1 | Read pair request |
| rd_addr_a | input | 8 | Port A read address |
| rd_addr_b | input | 8 | Port B read address |
| rd_ready | output | 1 | Read pair can be accepted this cycle |
| rd_valid | output | 1 | Read data valid (one cycle after acceptance) |
| rd_data_a | output | 16 | Port A read word |
| rd_data_b | output | 16 | Port B read word |
| wr_en | input | 1 | Write request |
| wr_addr | input | 8 | Write address |
| wr_data | input | 16 | Write word |
| wr_ready | output | 1 | Write can be accepted (no write in flight) |

## Verification
The assertions cover the handshake timing on every cycle: `rd_valid` follows an accepted pair by one cycle and only then, a write closes `wr_ready` for exactly one cycle, reads are refused during writes, and identical addresses yield equal words. Whether a rebuilt word is actually right depends on the parity bank having tracked every earlier write. Only the bench scenarios can show that, by comparing every returned word against a reference array after exhaustive address fills, sweeps over same-bank pairs, and random writes interleaved with forced conflicts.

// File: rtl/xpm_pkg.sv
// Package: shared types for the dual-read parity memory.
// Assumes: nothing beyond IEEE 1800-2017.
package xpm_pkg;

    // Write sequencer state: idle, or committing the word and parity.
    typedef enum logic {
        WR_IDLE   = 1'b0,
        WR_COMMIT = 1'b1
    } wr_state_e;

    // Builds a mask with every bank enabled except the one given.
    function automatic logic [7:0] all_but(input int unsigned nb, input int unsigned sel);
        logic [7:0] m;
        m = '0;
        for (int i = 0; i < 8; i++) begin
            m[i] = (i < nb) && (i != sel);
        end
        return m;
    endfunction

endpackage

// File: rtl/xpm_bank.sv
// Module: single-port storage bank with registered read data.
// Does: one read or one write per cycle; the read word appears the cycle after.
// Assumes: rdata holds its last read value while no read is issued;
// synchronous reset clears every row so that parity starts consistent.
module xpm_bank #(
    parameter int DW   = 16,
    parameter int ROWS = 64,
    parameter int RW   = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          we,
    input  logic [RW-1:0] row,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [ROWS];

    // Storage array: cleared on reset, written on an enabled write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                mem[r] <= '0;
            end
        end else if (en && we) begin
            mem[row] <= wdata;
        end
    end

    // Read register: captures the addressed row on an enabled read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (en && !we) begin
            rdata <= mem[row];
        end
    end

endmodule

// File: rtl/xpm_steer.sv
// Module: per-cycle bank port steering.
// Does: decides which banks are accessed, at which row and in which direction,
// for a read pair, the first (gather) cycle of a write, or its commit cycle.
// Assumes: at most one of rd_fire / wr_fire / commit is active in a cycle
// (the top guarantees this); every bank sees at most one access.
module xpm_steer #(
    parameter int NB = 4,
    parameter int RW = 6,
    parameter int BW = $clog2(NB)
) (
    input  logic          rd_fire,
    input  logic [BW-1:0] bank_a,
    input  logic [RW-1:0] row_a,
    input  logic [BW-1:0] bank_b,
    input  logic [RW-1:0] row_b,
    input  logic          wr_fire,
    input  logic [BW-1:0] wr_bank,
    input  logic [RW-1:0] wr_row,
    input  logic          commit,
    input  logic [BW-1:0] cm_bank,
    input  logic [RW-1:0] cm_row,
    output logic [NB-1:0] bank_en,
    output logic [NB-1:0] bank_we,
    output logic [RW-1:0] bank_row [NB],
    output logic          par_en,
    output logic          par_we,
    output logic [RW-1:0] par_row,
    output logic          conflict
);

    // Conflict detect: same bank, different rows.
    always_comb begin
        conflict = rd_fire && (bank_a == bank_b) && (row_a != row_b);
    end

    for (genvar i = 0; i < NB; i++) begin : g_bank
        localparam logic [BW-1:0] IDX = BW'(i);

        // Port control for main bank i.
        always_comb begin
            bank_en[i]  = 1'b0;
            bank_we[i]  = 1'b0;
            bank_row[i] = '0;
            if (commit) begin
                bank_en[i]  = (IDX == cm_bank);
                bank_we[i]  = (IDX == cm_bank);
                bank_row[i] = cm_row;
            end else if (wr_fire) begin
                bank_en[i]  = (IDX != wr_bank);
                bank_row[i] = wr_row;
            end else if (rd_fire) begin
                if (IDX == bank_a) begin
                    bank_en[i]  = 1'b1;
                    bank_row[i] = row_a;
                end else if (IDX == bank_b || conflict) begin
                    bank_en[i]  = 1'b1;
                    bank_row[i] = row_b;
                end
            end
        end
    end

    // Port control for the parity bank.
    always_comb begin
        par_en  = 1'b0;
        par_we  = 1'b0;
        par_row = '0;
        if (commit) begin
            par_en  = 1'b1;
            par_we  = 1'b1;
            par_row = cm_row;
        end else if (conflict) begin
            par_en  = 1'b1;
            par_row = row_b;
        end
    end

endmodule

// File: rtl/xpm_xor_reduce.sv
// Module: masked XOR combiner.
// Does: XORs a seed word with every bank word whose mask bit is set.
// Used both to rebuild a conflicted read word and to form new parity.
// Assumes: purely combinational; depth grows as log2(NB+1) XOR levels.
module xpm_xor_reduce #(
    parameter int NB = 4,
    parameter int DW = 16
) (
    input  logic [DW-1:0] words [NB],
    input  logic [NB-1:0] mask,
    input  logic [DW-1:0] seed,
    output logic [DW-1:0] result
);

    // Reduction over the selected words.
    always_comb begin
        result = seed;
        for (int i = 0; i < NB; i++) begin
            if (mask[i]) begin
                result = result ^ words[i];
            end
        end
    end

endmodule

// File: rtl/xpm_dualread.sv
// Module: dual-read memory built from single-port banks plus an XOR parity bank.
// Does: serves two reads per cycle; a same-bank conflict is resolved by
// rebuilding port B from parity. One write port updates word and parity over
// two cycles, holding reads off meanwhile.
// Assumes: NB is a power of two no larger than 8; reset clears all banks.
module xpm_dualread #(
    parameter int NB   = 4,
    parameter int DW   = 16,
    parameter int ROWS = 64,
    parameter int AW   = $clog2(NB * ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic          rd_ready,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data_a,
    output logic [DW-1:0] rd_data_b,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          wr_ready
);
    import xpm_pkg::*;

    localparam int BW = $clog2(NB);
    localparam int RW = $clog2(ROWS);

    wr_state_e     wstate;
    logic          rd_fire, wr_fire, commit, conflict;
    logic [BW-1:0] cm_bank;
    logic [RW-1:0] cm_row;
    logic [DW-1:0] cm_data;

    logic [NB-1:0] bank_en, bank_we;
    logic [RW-1:0] bank_row [NB];
    logic [DW-1:0] bank_q   [NB];
    logic          par_en, par_we;
    logic [RW-1:0] par_row;
    logic [DW-1:0] par_q, dec_out, dec_seed;
    logic [NB-1:0] dec_mask;

    logic          rsp_valid, rsp_conflict;
    logic [BW-1:0] rsp_bank_a, rsp_bank_b;

    // Handshake: writes win a shared cycle; reads wait out a commit.
    always_comb begin
        wr_ready = (wstate == WR_IDLE);
        rd_ready = (wstate == WR_IDLE) && !wr_en;
        rd_fire  = rd_en && rd_ready;
        wr_fire  = wr_en && wr_ready;
        commit   = (wstate == WR_COMMIT);
    end

    // Write sequencer: captures the write and runs the commit cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wstate  <= WR_IDLE;
            cm_bank <= '0;
            cm_row  <= '0;
            cm_data <= '0;
        end else if (wr_fire) begin
            wstate  <= WR_COMMIT;
            cm_bank <= wr_addr[BW-1:0];
            cm_row  <= wr_addr[AW-1:BW];
            cm_data <= wr_data;
        end else begin
            wstate  <= WR_IDLE;
        end
    end

    xpm_steer #(.NB(NB), .RW(RW), .BW(BW)) u_steer (
        .rd_fire  (rd_fire),
        .bank_a   (rd_addr_a[BW-1:0]),
        .row_a    (rd_addr_a[AW-1:BW]),
        .bank_b   (rd_addr_b[BW-1:0]),
        .row_b    (rd_addr_b[AW-1:BW]),
        .wr_fire  (wr_fire),
        .wr_bank  (wr_addr[BW-1:0]),
        .wr_row   (wr_addr[AW-1:BW]),
        .commit   (commit),
        .cm_bank  (cm_bank),
        .cm_row   (cm_row),
        .bank_en  (bank_en),
        .bank_we  (bank_we),
        .bank_row (bank_row),
        .par_en   (par_en),
        .par_we   (par_we),
        .par_row  (par_row),
        .conflict (conflict)
    );

    for (genvar i = 0; i < NB; i++) begin : g_main
        xpm_bank #(.DW(DW), .ROWS(ROWS), .RW(RW)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (bank_en[i]),
            .we    (bank_we[i]),
            .row   (bank_row[i]),
            .wdata (cm_data),
            .rdata (bank_q[i])
        );
    end

    xpm_bank #(.DW(DW), .ROWS(ROWS), .RW(RW)) u_parity (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (par_en),
        .we    (par_we),
        .row   (par_row),
        .wdata (dec_out),
        .rdata (par_q)
    );

    // Response tracking: remembers the banks used and whether B is decoded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_conflict <= 1'b0;
            rsp_bank_a   <= '0;
            rsp_bank_b   <= '0;
        end else begin
            rsp_valid    <= rd_fire;
            rsp_conflict <= conflict;
            rsp_bank_a   <= rd_addr_a[BW-1:0];
            rsp_bank_b   <= rd_addr_b[BW-1:0];
        end
    end

    // Shared combiner input: new parity in commit, port B rebuild otherwise.
    always_comb begin
        if (commit) begin
            dec_mask = NB'(all_but(NB, int'(cm_bank)));
            dec_seed = cm_data;
        end else begin
            dec_mask = NB'(all_but(NB, int'(rsp_bank_a)));
            dec_seed = par_q;
        end
    end

    xpm_xor_reduce #(.NB(NB), .DW(DW)) u_xor (
        .words  (bank_q),
        .mask   (dec_mask),
        .seed   (dec_seed),
        .result (dec_out)
    );

    // Output steering: A always direct, B direct or rebuilt.
    always_comb begin
        rd_valid  = rsp_valid;
        rd_data_a = bank_q[rsp_bank_a];
        rd_data_b = rsp_conflict ? dec_out : bank_q[rsp_bank_b];
    end

endmodule

// File: rtl/xpm_dualread_checks.sv
// Module: protocol checker bound to xpm_dualread.
// Does: checks handshake timing and identical-address agreement each cycle.
// Assumes: sees only the top-level ports.
module xpm_dualread_checks #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr_a,
    input logic [AW-1:0] rd_addr_b,
    input logic          rd_ready,
    input logic          rd_valid,
    input logic [DW-1:0] rd_data_a,
    input logic [DW-1:0] rd_data_b,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          wr_ready
);

    // R1: an accepted pair yields valid data next cycle.
    assert_valid_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_ready) |=> rd_valid);

    // R1, R7: no accepted pair, no valid data next cycle.
    assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && rd_ready) |=> !rd_valid);

    // R6: an accepted write closes the write port for the next cycle.
    assert_write_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ready) |=> !wr_ready);

    // R6: the write port reopens one cycle after closing.
    assert_write_reopens_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |=> wr_ready);

    // R7: reads are refused while a write is requested or committing.
    assert_read_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || !wr_ready) |-> !rd_ready);

    // R5: identical accepted addresses return identical words.
    assert_same_addr_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_ready && rd_addr_a == rd_addr_b) |=> (rd_data_a == rd_data_b));

endmodule

bind xpm_dualread xpm_dualread_checks #(.DW(DW), .AW(AW)) u_checks (.*);

// File: tb/test_xpm_dualread.sv
module test_xpm_dualread;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int AW = 8;
    localparam int NADDR = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr_a = '0;
    logic [AW-1:0] rd_addr_b = '0;
    logic          rd_ready, rd_valid;
    logic [DW-1:0] rd_data_a, rd_data_b;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_ready;

    logic [DW-1:0] ref_mem [NADDR];
    int            n_checks = 0;
    int            n_fail = 0;
    int            cycles = 0;

    xpm_dualread i_xpm_dualread (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .rd_ready(rd_ready), .rd_valid(rd_valid),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(wr_ready)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            n_fail = n_fail + 1;
            $display("FAIL R1 watchdog expired actual=%0d cycles expected=<190000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pattern(input int a, input int salt);
        return DW'(a * 40503 + salt * 7919) ^ 16'hA5C3;
    endfunction

    // Issue one read pair and compare both words with the reference.
    task automatic do_read(input logic [AW-1:0] a, input logic [AW-1:0] b, input string req);
        @(negedge clk);
        rd_en = 1'b1; rd_addr_a = a; rd_addr_b = b;
        #1;
        check(rd_ready === 1'b1, {req, " rd_ready"}, 32'(rd_ready), 32'd1);
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_valid === 1'b1 && rd_data_a === ref_mem[a] && rd_data_b === ref_mem[b],
              req, {15'd0, rd_valid, rd_data_a}, {15'd1, ref_mem[a]});
        if (rd_data_b !== ref_mem[b])
            $display("  port B addr %h actual=%h expected=%h", b, rd_data_b, ref_mem[b]);
    endtask

    // Issue a write, try reads during it, and check the handshake (R6, R7).
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        rd_en = 1'b1; rd_addr_a = a; rd_addr_b = a ^ 8'h04;
        #1;
        check(rd_ready === 1'b0 && wr_ready === 1'b1, "R7 read refused with wr_en",
              {rd_ready, wr_ready}, 32'd1);
        @(negedge clk);
        wr_en = 1'b0;
        check(rd_valid === 1'b0, "R7 read ignored during wr_en", 32'(rd_valid), 32'd0);
        check(wr_ready === 1'b0 && rd_ready === 1'b0, "R6 write busy cycle",
              {rd_ready, wr_ready}, 32'd0);
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_valid === 1'b0, "R7 read ignored during commit", 32'(rd_valid), 32'd0);
        check(wr_ready === 1'b1, "R6 write port reopened", 32'(wr_ready), 32'd1);
        ref_mem[a] = d;
    endtask

    initial begin
        for (int i = 0; i < NADDR; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_valid === 1'b0 && wr_ready === 1'b1, "R8 reset state",
              {rd_valid, wr_ready}, 32'd1);

        // R8: all-zero after reset, including conflicting pairs.
        for (int a = 0; a < NADDR; a++) begin
            do_read(AW'(a), AW'(a ^ 8'h14), "R8 reset contents");
        end

        // R2: fill every address with a distinct computed word.
        for (int a = 0; a < NADDR; a++) begin
            do_write(AW'(a), pattern(a, 1));
        end

        // R3, R4, R5: sweep pairs; same bank -> conflict or identical.
        for (int a = 0; a < NADDR; a++) begin
            for (int b = 0; b < NADDR; b++) begin
                if ((a % 2) == (b % 2)) begin
                    if (a == b)
                        do_read(AW'(a), AW'(b), "R5 identical address");
                    else if ((a % 4) == (b % 4))
                        do_read(AW'(a), AW'(b), "R4 same-bank conflict");
                    else
                        do_read(AW'(a), AW'(b), "R3 different banks");
                end
            end
        end

        // R6, R4: random writes, then read the new word against a forced conflict.
        for (int it = 0; it < 3000; it++) begin
            logic [AW-1:0] wa, ra, rb;
            wa = AW'($urandom_range(0, NADDR - 1));
            do_write(wa, pattern(it, 7));
            ra = wa;
            rb = {AW'($urandom_range(0, 63)) << 2} | AW'(wa[1:0]);
            if (it % 2 == 0)
                do_read(ra, rb, "R6 read after write with R4 conflict");
            else
                do_read(rb, ra, "R4 decoded word after write");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule